// File: doc/BRIEF.md
# Dual-Oscillator Power Mode Controller

This block manages clocking and power states for a small 8-bit processor core that can run from either of two oscillators, called A and B. Software writes two control registers through a simple write port. The power register requests a light sleep (idle) or a deep sleep (power-down). The clock register chooses which oscillator drives the system and which oscillators stay running. The block drives an enable line for each oscillator and reads a ready line back from each one. It also produces clock-enable strobes for the processor and for the peripherals. Other logic uses these strobes to gate the real clocks.

The block never allows a clock setting that would stop the oscillator currently in use. Such a write is dropped and a sticky error flag is raised. In idle, the processor clock stops while the peripherals keep running. Any enabled interrupt ends idle. In power-down, both oscillators stop. Only an external interrupt request or a keyboard interrupt ends power-down. The oscillator that was selected when power-down began is then restarted. The processor clock comes back only once that oscillator reports ready.

Reset works the same way as a power-down wake-up. The oscillator choice is taken from a configuration input, and the processor waits for that oscillator to report ready.

Top module: `pmc_top`

## Requirements
- R1: While and after reset, the selected oscillator equals `boot_sel_a` (1 = A, 0 = B). The selected oscillator's enable is 1 and the other's is 0. `cpu_clk_en`, `per_clk_en`, `idle_flag`, `pd_flag` and `cfg_err` are all 0.
- R2: In normal mode, a write with `wr_addr`=1 loads the clock register. Bit 0 selects the oscillator (1 = A, 0 = B), bit 1 enables A and bit 2 enables B. A legal value appears on `clk_sel_a`, `osc_a_en` and `osc_b_en` after the next clock edge.
- R3: A clock write that would leave the selected oscillator disabled is ignored, and the previous settings remain. Leaving both oscillators disabled is a special case of this. Such a write sets `cfg_err`, which stays 1 until reset.
- R4: In normal mode, a write with `wr_addr`=0 and bit 0 = 1 enters idle. In idle, `cpu_clk_en`=0, `per_clk_en`=1, `idle_flag`=1, and the oscillator enables are unchanged. A power write with bits 1:0 = 0 has no effect.
- R5: In idle, a high `irq_any`, `irq_ext` or `irq_kbd` returns the block to normal mode after one edge. `idle_flag` is then cleared, `cpu_clk_en`=1, and the oscillator enables and selection are unchanged.
- R6: In normal mode, a power write with bit 1 = 1 enters power-down, even if bit 0 is also 1. In power-down, both oscillator enables and both clock enables are 0, and `pd_flag`=1.
- R7: Power-down ends only on `irq_ext` or `irq_kbd`; `irq_any` alone is ignored. On exit, `pd_flag` is cleared. The oscillator selected at entry is re-enabled, and the unselected oscillator stays stopped.
- R8: After a reset or a power-down wake-up, `cpu_clk_en` and `per_clk_en` stay 0 until the selected oscillator's ready input is sampled high. They become 1 after that edge.
- R9: Writes to either register are ignored outside normal mode (idle, power-down, waiting for ready).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_sel_a | input | 1 | Oscillator choice loaded at reset: 1 = A, 0 = B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = power register, 1 = clock register |
| wr_data | input | DATA_W | Write data |
| irq_any | input | 1 | Any enabled interrupt request |
| irq_ext | input | 1 | Enabled external interrupt request (either of the two external lines) |
| irq_kbd | input | 1 | Enabled keyboard interrupt request |
| osc_a_rdy | input | 1 | Oscillator A stable |
| osc_b_rdy | input | 1 | Oscillator B stable |
| osc_a_en | output | 1 | Run oscillator A |
| osc_b_en | output | 1 | Run oscillator B |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_sel_a | output | 1 | 1 = system runs from A, 0 = from B |
| idle_flag | output | 1 | Block is in idle |
| pd_flag | output | 1 | Block is in power-down |
| cfg_err | output | 1 | Sticky illegal clock-write flag |

## Verification
The hardest case to reach is the restart after power-down when oscillator B was the one selected and A was also running before entry. Only that case shows that the unselected oscillator stays stopped and that the processor clock waits for B's ready input. The stimulus reaches it in three steps. It resets with `boot_sel_a` low, then enables A while B stays selected. Finally it drops `osc_b_rdy` around the power-down and wake-up, so the wait for the ready input can be observed over several cycles. Illegal writes issued during idle confirm that they neither change the settings nor set the error flag.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_NORM = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2,
    PM_WAKE = 2'd3
  } pm_mode_e;

  localparam int PWR_IDLE_BIT = 0;
  localparam int PWR_DOWN_BIT = 1;
  localparam int CLK_SEL_BIT  = 0;
  localparam int CLK_AEN_BIT  = 1;
  localparam int CLK_BEN_BIT  = 2;
  localparam int CLK_FIELD_W  = 3;

  // legal when the chosen oscillator runs (this also excludes "both off")
  function automatic logic osc_combo_ok(input logic sel_a, input logic en_a,
                                        input logic en_b);
    return (en_a | en_b) & (sel_a ? en_a : en_b);
  endfunction
endpackage

// File: rtl/pmc_osc_cfg.sv
module pmc_osc_cfg
  import pmc_pkg::*;
#(
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_sel_a,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              down_enter,
  output logic              sel_a,
  output logic              en_a,
  output logic              en_b,
  output logic              cfg_err
);
  logic new_sel, new_a, new_b, new_ok;

  assign new_sel = wr_data[CLK_SEL_BIT];
  assign new_a   = wr_data[CLK_AEN_BIT];
  assign new_b   = wr_data[CLK_BEN_BIT];
  assign new_ok  = osc_combo_ok(new_sel, new_a, new_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_a   <= boot_sel_a;
      en_a    <= boot_sel_a;
      en_b    <= ~boot_sel_a;
      cfg_err <= 1'b0;
    end else if (wr_ok) begin
      if (new_ok) begin
        sel_a <= new_sel;
        en_a  <= new_a;
        en_b  <= new_b;
      end else begin
        cfg_err <= 1'b1;
      end
    end else if (down_enter) begin
      // only the selected oscillator is brought back on wake-up
      if (sel_a) en_b <= 1'b0;
      else       en_a <= 1'b0;
    end
  end

  p_sel_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a ? en_a : en_b));

  p_bad_write_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !new_ok) |=> (cfg_err && $stable(sel_a) && $stable(en_a) && $stable(en_b)));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/pmc_pwr_fsm.sv
module pmc_pwr_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_pwr,
  input  logic     req_idle,
  input  logic     req_down,
  input  logic     irq_any,
  input  logic     irq_ext,
  input  logic     irq_kbd,
  input  logic     sel_rdy,
  output pm_mode_e mode,
  output logic     down_enter
);
  pm_mode_e mode_nx;

  assign down_enter = (mode == PM_NORM) && wr_pwr && req_down;

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      PM_NORM: begin
        if (down_enter)              mode_nx = PM_DOWN;
        else if (wr_pwr && req_idle) mode_nx = PM_IDLE;
      end
      PM_IDLE: if (irq_any || irq_ext || irq_kbd) mode_nx = PM_NORM;
      PM_DOWN: if (irq_ext || irq_kbd)            mode_nx = PM_WAKE;
      PM_WAKE: if (sel_rdy)                       mode_nx = PM_NORM;
      default: mode_nx = PM_WAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= PM_WAKE;
    else        mode <= mode_nx;
  end

  p_down_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NORM && wr_pwr && req_down && req_idle) |=> (mode == PM_DOWN));

  p_down_wake_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_DOWN && !irq_ext && !irq_kbd) |=> (mode == PM_DOWN));

  p_wake_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_WAKE && !sel_rdy) |=> (mode == PM_WAKE));
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  pm_mode_e mode,
  input  logic     en_a,
  input  logic     en_b,
  output logic     osc_a_en,
  output logic     osc_b_en,
  output logic     cpu_clk_en,
  output logic     per_clk_en
);
  logic osc_hold;

  assign osc_hold   = (mode != PM_DOWN);
  assign osc_a_en   = osc_hold & en_a;
  assign osc_b_en   = osc_hold & en_b;
  assign cpu_clk_en = (mode == PM_NORM);
  assign per_clk_en = (mode == PM_NORM) || (mode == PM_IDLE);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int DATA_W = CLK_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_sel_a,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_any,
  input  logic              irq_ext,
  input  logic              irq_kbd,
  input  logic              osc_a_rdy,
  input  logic              osc_b_rdy,
  output logic              osc_a_en,
  output logic              osc_b_en,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              clk_sel_a,
  output logic              idle_flag,
  output logic              pd_flag,
  output logic              cfg_err
);
  pm_mode_e mode;
  logic wr_pwr, wr_clk_ok, down_enter, sel_rdy, en_a, en_b;

  assign wr_pwr    = wr_en && !wr_addr;
  assign wr_clk_ok = wr_en && wr_addr && (mode == PM_NORM);
  assign sel_rdy   = clk_sel_a ? osc_a_rdy : osc_b_rdy;
  assign idle_flag = (mode == PM_IDLE);
  assign pd_flag   = (mode == PM_DOWN);

  pmc_pwr_fsm u_fsm (
    .clk, .rst_n, .wr_pwr,
    .req_idle (wr_data[PWR_IDLE_BIT]),
    .req_down (wr_data[PWR_DOWN_BIT]),
    .irq_any, .irq_ext, .irq_kbd, .sel_rdy,
    .mode, .down_enter
  );

  pmc_osc_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk, .rst_n, .boot_sel_a,
    .wr_ok (wr_clk_ok), .wr_data, .down_enter,
    .sel_a (clk_sel_a), .en_a, .en_b, .cfg_err
  );

  pmc_clk_gate u_gate (
    .mode, .en_a, .en_b,
    .osc_a_en, .osc_b_en, .cpu_clk_en, .per_clk_en
  );

  p_down_osc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_flag |-> (!osc_a_en && !osc_b_en && !per_clk_en));

  p_idle_exit_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idle_flag) && !idle_flag) |->
      ($stable(clk_sel_a) && $stable(osc_a_en) && $stable(osc_b_en)));

  p_cpu_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && !$past(idle_flag)) |->
      $past(clk_sel_a ? osc_a_rdy : osc_b_rdy));

  p_restart_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_flag) && !pd_flag) |->
      (clk_sel_a ? (osc_a_en && !osc_b_en) : (osc_b_en && !osc_a_en)));
endmodule

// File: tb/pmc_top_tb.sv
module pmc_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_sel_a = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [2:0] wr_data = '0;
  logic irq_any = 1'b0, irq_ext = 1'b0, irq_kbd = 1'b0;
  logic osc_a_rdy = 1'b0, osc_b_rdy = 1'b0;
  logic osc_a_en, osc_b_en, cpu_clk_en, per_clk_en, clk_sel_a, idle_flag, pd_flag, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmc_top u_dut (
    .clk, .rst_n, .boot_sel_a, .wr_en, .wr_addr, .wr_data,
    .irq_any, .irq_ext, .irq_kbd, .osc_a_rdy, .osc_b_rdy,
    .osc_a_en, .osc_b_en, .cpu_clk_en, .per_clk_en, .clk_sel_a,
    .idle_flag, .pd_flag, .cfg_err
  );

  // observed = {a_en, b_en, cpu, per, sel_a, idle, pd, err}
  function automatic logic [7:0] obs();
    return {osc_a_en, osc_b_en, cpu_clk_en, per_clk_en, clk_sel_a, idle_flag, pd_flag, cfg_err};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, obs(), exp);
    end
  endtask

  // vector = {wr_en, wr_addr, data[2:0], irq_any, irq_ext, irq_kbd, rdy_a, rdy_b, expected[7:0]}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b0,3'h0,5'b00010,8'b10111000},  // R8 ready seen -> running
    {1'b1,1'b1,3'h7,5'b00010,8'b11111000},  // R2 A sel, both on
    {1'b1,1'b1,3'h6,5'b00010,8'b11110000},  // R2 B sel, both on
    {1'b1,1'b1,3'h4,5'b00010,8'b01110000},  // R2 B only
    {1'b1,1'b1,3'h1,5'b00010,8'b01110001},  // R3 both off rejected
    {1'b1,1'b1,3'h5,5'b00010,8'b01110001},  // R3 stop selected rejected
    {1'b1,1'b1,3'h3,5'b00010,8'b10111001},  // R2 A only, err sticky
    {1'b1,1'b0,3'h1,5'b00010,8'b10011101},  // R4 idle
    {1'b1,1'b1,3'h6,5'b00010,8'b10011101},  // R9 write in idle ignored
    {1'b0,1'b0,3'h0,5'b10010,8'b10111001},  // R5 irq_any ends idle
    {1'b1,1'b0,3'h3,5'b00000,8'b00001011},  // R6 both bits -> power-down
    {1'b0,1'b0,3'h0,5'b10000,8'b00001011},  // R7 irq_any ignored
    {1'b0,1'b0,3'h0,5'b00100,8'b10001001},  // R7 keyboard wakes, A restarted
    {1'b0,1'b0,3'h0,5'b00000,8'b10001001},  // R8 waits for ready
    {1'b0,1'b0,3'h0,5'b00010,8'b10111001}   // R8 ready -> running
  };
  string vtag [NV] = '{"R8","R2","R2","R2","R3","R3","R2","R4","R9","R5","R6","R7","R7","R8","R8"};

  task automatic step(input logic we, input logic wa, input logic [2:0] wd,
                      input logic [4:0] ctl);
    wr_en = we; wr_addr = wa; wr_data = wd;
    {irq_any, irq_ext, irq_kbd, osc_a_rdy, osc_b_rdy} = ctl;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset sel A", 8'b10001000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16], VEC[i][15:13], VEC[i][12:8]);
      check(vtag[i], VEC[i][7:0]);
    end

    // second reset, boot from B; error must clear
    rst_n = 1'b0; boot_sel_a = 1'b0;
    step(1'b0, 1'b0, 3'h0, 5'b00000);
    check("R1 reset sel B", 8'b01000000);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 3'h0, 5'b00000);
    check("R8 no ready after reset", 8'b01000000);
    step(1'b0, 1'b0, 3'h0, 5'b00001);
    check("R8 B ready", 8'b01110000);
    step(1'b1, 1'b1, 3'h6, 5'b00001);
    check("R2 A on, B sel", 8'b11110000);
    step(1'b1, 1'b0, 3'h2, 5'b00000);
    check("R6 power-down from B", 8'b00000010);
    step(1'b1, 1'b1, 3'h7, 5'b00000);
    check("R9 write in power-down", 8'b00000010);
    step(1'b0, 1'b0, 3'h0, 5'b01000);
    check("R7 ext wake B only", 8'b01000000);
    step(1'b1, 1'b1, 3'h0, 5'b00000);
    check("R9 write while waiting", 8'b01000000);
    step(1'b0, 1'b0, 3'h0, 5'b00001);
    check("R8 B ready again", 8'b01110000);
    step(1'b1, 1'b0, 3'h0, 5'b00001);
    check("R4 zero power write", 8'b01110000);
    step(1'b1, 1'b0, 3'h1, 5'b00001);
    check("R4 idle from B", 8'b01010100);
    step(1'b1, 1'b1, 3'h0, 5'b00001);
    check("R9 bad write in idle", 8'b01010100);
    step(1'b0, 1'b0, 3'h0, 5'b01001);
    check("R5 ext ends idle", 8'b01110000);
    step(1'b1, 1'b1, 3'h0, 5'b00001);
    check("R3 both off rejected", 8'b01110001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule